// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command, address, clock-enable and mask pins of a single-data-rate SDRAM from reset until the memory can take normal traffic. It first holds a no-operation command with clock enable and the data masks high for a programmable pause. It then closes every bank with a precharge-all command and issues a configurable number of auto-refresh commands. Last, it loads the mode register. Each step waits a set interval before the next one, and once the mode-register load has settled the block raises `initDone`.

All waits are parameters. The pause, the precharge-to-command wait and the refresh cycle time are given in nanoseconds, together with the clock period in picoseconds. At elaboration each interval becomes a cycle count: the interval is divided by the period and any fraction is rounded up. The refresh cycle time and the precharge wait are never fewer than two cycles. The mode word is assembled from parameters for CAS latency, burst type, burst length and write mode. One down-counter, reloaded at each step, times the whole sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rstN` is low, and after a release until the pause ends, the pins carry NOP (`sdCsN`=0, `sdRasN`=`sdCasN`=`sdWeN`=1, `sdBa`=0, `sdAddr`=0), `sdCke`=1, every `sdDqm` bit is 1 and `initDone`=0. A reset in mid-run restarts the sequence from the pause.
- R2: The pause length is PAUSE_CYC = ceil(PAUSE_NS*1000/CLK_PERIOD_PS). Counting the first rising edge after reset release as cycle 1, the pins show only NOP through cycle PAUSE_CYC-1.
- R3: In cycle PAUSE_CYC the pins show precharge-all for exactly one cycle: `sdCsN`=0, `sdRasN`=0, `sdCasN`=1, `sdWeN`=0, `sdAddr`[10]=1, all other address bits and `sdBa` zero.
- R4: The first auto-refresh appears exactly RP_CYC cycles after the precharge. Auto-refresh is `sdCsN`=`sdRasN`=`sdCasN`=0 and `sdWeN`=1, with the address zero.
- R5: Exactly REFRESH_COUNT auto-refresh commands are issued, and consecutive ones are exactly RC_CYC cycles apart. Every command is present for one cycle, with NOP between commands.
- R6: A nanosecond interval is turned into clocks by rounding up: RP_CYC = max(2, ceil(TRP_NS*1000/CLK_PERIOD_PS)) and RC_CYC = max(2, ceil(TRC_NS*1000/CLK_PERIOD_PS)). For example, 63 ns at a 5 ns clock gives 13 cycles.
- R7: The mode-register load appears exactly RC_CYC cycles after the last refresh. It has all four strobes low, and `sdBa`, `sdAddr`[11], `sdAddr`[10], `sdAddr`[8] and `sdAddr`[7] all zero.
- R8: In the mode word, `sdAddr`[6:4] holds the CAS latency code (010 for 2, 011 for 3). `sdAddr`[3] holds the burst type (1 = interleaved). `sdAddr`[2:0] holds the burst length code: 000, 001, 010 and 011 for lengths 1, 2, 4 and 8, and 111 for any other length (full page).
- R9: `sdAddr`[9] of the mode word is 1 when SINGLE_WRITE is set (single-location writes) and 0 otherwise (burst writes).
- R10: `initDone` rises exactly MRD_CYC = max(2, MRD_CYCLES) cycles after the mode-register load. It stays high until reset, and no further command is issued.
- R11: Outside reset, `sdCke` and every `sdDqm` bit stay high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset; restarts the sequence |
| sdCke | output | 1 | Clock enable to the memory, held high |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BA_W | Bank select, zero throughout |
| sdAddr | output | ADDR_W | Address: bit 10 for precharge-all, mode word for the register load |
| sdDqm | output | DQM_W | Data masks, held high |
| initDone | output | 1 | High once the sequence is complete |

## Verification
The sequence runs with a 5 ns clock. The refresh cycle time of 63 ns does not divide evenly by the period, so a gap of 13 rather than 12 cycles shows the rounding up, while the 15 ns precharge wait divides exactly and shows that no extra cycle is added. Three instances with different mode settings give three distinct mode words. Between them they change every field: latency 2 against 3, sequential against interleaved, lengths 4, 8 and full page, and burst against single write. A fault in any single field therefore shows up as a mismatch. A reset applied after completion shows that the pause restarts and `initDone` falls.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_RP_WAIT,
    ST_RC_WAIT,
    ST_MRD_WAIT,
    ST_DONE
  } seqState_t;

  // Strobes from control to datapath; each is high for one cycle
  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic issueMrs;
    logic finish;
  } seqStrobe_t;

  // Interval in ns -> clock count, fraction rounded up
  function automatic int nsToCycles(input int ns, input int periodPs);
    longint prod;
    prod = longint'(ns) * 64'sd1000;
    return int'((prod + longint'(periodPs) - 64'sd1) / longint'(periodPs));
  endfunction

  function automatic int atLeast(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic [2:0] latencyCode(input int cl);
    return (cl == 2) ? 3'b010 : 3'b011;
  endfunction

  function automatic logic [2:0] lengthCode(input int bl);
    case (bl)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  // 12-bit mode word: write mode on 9, latency on 6:4, type on 3, length on 2:0
  function automatic logic [11:0] buildMode(input int cl, input bit interleave,
                                            input int bl, input bit singleWrite);
    logic [11:0] w;
    w = '0;
    w[9]   = singleWrite;
    w[6:4] = latencyCode(cl);
    w[3]   = interleave;
    w[2:0] = lengthCode(bl);
    return w;
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int PAUSE_CYC     = 28572,
  parameter int RP_CYC        = 3,
  parameter int RC_CYC        = 9,
  parameter int MRD_CYC       = 2,
  parameter int REFRESH_COUNT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  output seqStrobe_t strobe
);

  localparam int MAX_WAIT = maxOf4(PAUSE_CYC, RP_CYC, RC_CYC, MRD_CYC);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int REF_W    = (REFRESH_COUNT > 1) ? $clog2(REFRESH_COUNT) : 1;

  seqState_t          state, nextState;
  logic [CNT_W-1:0]   waitCnt, nextCnt;
  logic [REF_W-1:0]   refLeft, nextRef;
  logic               cntZero;

  assign cntZero = (waitCnt == '0);

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextRef   = refLeft;
    nextCnt   = cntZero ? '0 : waitCnt - 1'b1;
    case (state)
      ST_PAUSE: begin
        if (cntZero) begin
          strobe.issuePre = 1'b1;
          nextState       = ST_RP_WAIT;
          nextCnt         = CNT_W'(RP_CYC - 1);
        end
      end
      ST_RP_WAIT: begin
        if (cntZero) begin
          strobe.issueRef = 1'b1;
          nextState       = ST_RC_WAIT;
          nextCnt         = CNT_W'(RC_CYC - 1);
          nextRef         = REF_W'(REFRESH_COUNT - 1);
        end
      end
      ST_RC_WAIT: begin
        if (cntZero) begin
          if (refLeft != '0) begin
            strobe.issueRef = 1'b1;
            nextRef         = refLeft - 1'b1;
            nextCnt         = CNT_W'(RC_CYC - 1);
          end else begin
            strobe.issueMrs = 1'b1;
            nextState       = ST_MRD_WAIT;
            nextCnt         = CNT_W'(MRD_CYC - 1);
          end
        end
      end
      ST_MRD_WAIT: begin
        if (cntZero) begin
          strobe.finish = 1'b1;
          nextState     = ST_DONE;
        end
      end
      default: begin
        nextState = ST_DONE;
        nextCnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PAUSE;
      waitCnt <= CNT_W'(PAUSE_CYC - 1);
      refLeft <= '0;
    end else begin
      state   <= nextState;
      waitCnt <= nextCnt;
      refLeft <= nextRef;
    end
  end

endmodule

// File: rtl/sdram_init_datapath.sv
module sdram_init_datapath
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int DQM_W        = 2,
  parameter int CAS_LATENCY  = 2,
  parameter int BURST_LEN    = 4,
  parameter bit INTERLEAVE   = 1'b0,
  parameter bit SINGLE_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BA_W-1:0]   sdBa,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [DQM_W-1:0]  sdDqm,
  output logic              initDone
);

  localparam logic [11:0]       MODE12    = buildMode(CAS_LATENCY, INTERLEAVE, BURST_LEN, SINGLE_WRITE);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE12);

  logic              rasNext, casNext, weNext;
  logic [ADDR_W-1:0] addrNext;

  // Strobes are exclusive; default is NOP with a zero address
  always_comb begin
    rasNext  = 1'b1;
    casNext  = 1'b1;
    weNext   = 1'b1;
    addrNext = '0;
    if (strobe.issuePre) begin
      rasNext      = 1'b0;
      weNext       = 1'b0;
      addrNext[10] = 1'b1;
    end else if (strobe.issueRef) begin
      rasNext = 1'b0;
      casNext = 1'b0;
    end else if (strobe.issueMrs) begin
      rasNext  = 1'b0;
      casNext  = 1'b0;
      weNext   = 1'b0;
      addrNext = MODE_WORD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdCke    <= 1'b1;
      sdCsN    <= 1'b0;
      sdRasN   <= 1'b1;
      sdCasN   <= 1'b1;
      sdWeN    <= 1'b1;
      sdBa     <= '0;
      sdAddr   <= '0;
      sdDqm    <= '1;
      initDone <= 1'b0;
    end else begin
      sdCke    <= 1'b1;
      sdCsN    <= 1'b0;
      sdRasN   <= rasNext;
      sdCasN   <= casNext;
      sdWeN    <= weNext;
      sdBa     <= '0;
      sdAddr   <= addrNext;
      sdDqm    <= '1;
      initDone <= initDone | strobe.finish;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 7000,
  parameter int PAUSE_NS      = 200000,
  parameter int TRP_NS        = 15,
  parameter int TRC_NS        = 63,
  parameter int MRD_CYCLES    = 2,
  parameter int REFRESH_COUNT = 8,
  parameter int CAS_LATENCY   = 2,
  parameter int BURST_LEN     = 4,
  parameter bit INTERLEAVE    = 1'b0,
  parameter bit SINGLE_WRITE  = 1'b0,
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 2
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BA_W-1:0]   sdBa,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [DQM_W-1:0]  sdDqm,
  output logic              initDone
);

  localparam int PAUSE_CYC = atLeast(nsToCycles(PAUSE_NS, CLK_PERIOD_PS), 1);
  localparam int RP_CYC    = atLeast(nsToCycles(TRP_NS, CLK_PERIOD_PS), 2);
  localparam int RC_CYC    = atLeast(nsToCycles(TRC_NS, CLK_PERIOD_PS), 2);
  localparam int MRD_CYC   = atLeast(MRD_CYCLES, 2);

  seqStrobe_t strobe;

  sdram_init_ctrl #(
    .PAUSE_CYC    (PAUSE_CYC),
    .RP_CYC       (RP_CYC),
    .RC_CYC       (RC_CYC),
    .MRD_CYC      (MRD_CYC),
    .REFRESH_COUNT(REFRESH_COUNT)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  sdram_init_datapath #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .DQM_W       (DQM_W),
    .CAS_LATENCY (CAS_LATENCY),
    .BURST_LEN   (BURST_LEN),
    .INTERLEAVE  (INTERLEAVE),
    .SINGLE_WRITE(SINGLE_WRITE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sdCke   (sdCke),
    .sdCsN   (sdCsN),
    .sdRasN  (sdRasN),
    .sdCasN  (sdCasN),
    .sdWeN   (sdWeN),
    .sdBa    (sdBa),
    .sdAddr  (sdAddr),
    .sdDqm   (sdDqm),
    .initDone(initDone)
  );

endmodule

// File: rtl/sdram_init_checker.sv
module sdram_init_checker
  import sdram_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 7000,
  parameter int PAUSE_NS      = 200000,
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdCke,
  input logic              sdCsN,
  input logic              sdRasN,
  input logic              sdCasN,
  input logic              sdWeN,
  input logic [BA_W-1:0]   sdBa,
  input logic [ADDR_W-1:0] sdAddr,
  input logic [DQM_W-1:0]  sdDqm,
  input logic              initDone
);

  localparam int PAUSE_CYC = atLeast(nsToCycles(PAUSE_NS, CLK_PERIOD_PS), 1);

  logic [31:0] sinceRst;
  logic        isNop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != '1)   sinceRst <= sinceRst + 32'd1;
  end

  assign isNop = !sdCsN && sdRasN && sdCasN && sdWeN;

  AST_PAUSE_ONLY_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 32'(PAUSE_CYC)) |-> isNop);  // R2

  AST_PRECHARGE_ALL_A10: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN && sdCasN && !sdWeN) |-> (sdAddr[10] && !sdCsN));  // R3

  AST_COMMAND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !isNop |=> isNop);  // R5

  AST_MRS_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN && !sdCasN && !sdWeN) |->
      (sdBa == '0 && !sdAddr[11] && !sdAddr[10] && !sdAddr[8] && !sdAddr[7]));  // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);  // R10

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> isNop);  // R10

  AST_CKE_DQM_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sdCke && (&sdDqm)));  // R11

endmodule

bind sdram_init_seq sdram_init_checker #(
  .CLK_PERIOD_PS(CLK_PERIOD_PS),
  .PAUSE_NS     (PAUSE_NS),
  .ADDR_W       (ADDR_W),
  .BA_W         (BA_W),
  .DQM_W        (DQM_W)
) u_initChk (
  .clk     (clk),
  .rstN    (rstN),
  .sdCke   (sdCke),
  .sdCsN   (sdCsN),
  .sdRasN  (sdRasN),
  .sdCasN  (sdCasN),
  .sdWeN   (sdWeN),
  .sdBa    (sdBa),
  .sdAddr  (sdAddr),
  .sdDqm   (sdDqm),
  .initDone(initDone)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  // instance A: CL2, sequential, length 4, burst write
  logic aCke, aCs, aRas, aCas, aWe, aDone;
  logic [1:0] aBa, aDqm;
  logic [11:0] aAddr;
  // instance B: CL3, interleaved, length 8, single write
  logic bCke, bCs, bRas, bCas, bWe, bDone;
  logic [1:0] bBa, bDqm;
  logic [11:0] bAddr;
  // instance C: CL2, sequential, full page, burst write
  logic cCke, cCs, cRas, cCas, cWe, cDone;
  logic [1:0] cBa, cDqm;
  logic [11:0] cAddr;

  sdram_init_seq #(.CLK_PERIOD_PS(5000), .PAUSE_NS(1000), .TRP_NS(15), .TRC_NS(63),
    .MRD_CYCLES(2), .REFRESH_COUNT(8), .CAS_LATENCY(2), .BURST_LEN(4),
    .INTERLEAVE(1'b0), .SINGLE_WRITE(1'b0)) u_sdram_init_seq (
    .clk(clk), .rstN(rstN), .sdCke(aCke), .sdCsN(aCs), .sdRasN(aRas), .sdCasN(aCas),
    .sdWeN(aWe), .sdBa(aBa), .sdAddr(aAddr), .sdDqm(aDqm), .initDone(aDone));

  sdram_init_seq #(.CLK_PERIOD_PS(5000), .PAUSE_NS(1000), .TRP_NS(15), .TRC_NS(63),
    .MRD_CYCLES(2), .REFRESH_COUNT(8), .CAS_LATENCY(3), .BURST_LEN(8),
    .INTERLEAVE(1'b1), .SINGLE_WRITE(1'b1)) u_seqB (
    .clk(clk), .rstN(rstN), .sdCke(bCke), .sdCsN(bCs), .sdRasN(bRas), .sdCasN(bCas),
    .sdWeN(bWe), .sdBa(bBa), .sdAddr(bAddr), .sdDqm(bDqm), .initDone(bDone));

  sdram_init_seq #(.CLK_PERIOD_PS(5000), .PAUSE_NS(1000), .TRP_NS(15), .TRC_NS(63),
    .MRD_CYCLES(2), .REFRESH_COUNT(8), .CAS_LATENCY(2), .BURST_LEN(512),
    .INTERLEAVE(1'b0), .SINGLE_WRITE(1'b0)) u_seqC (
    .clk(clk), .rstN(rstN), .sdCke(cCke), .sdCsN(cCs), .sdRasN(cRas), .sdCasN(cCas),
    .sdWeN(cWe), .sdBa(cBa), .sdAddr(cAddr), .sdDqm(cDqm), .initDone(cDone));

  // Expected command schedule for instance A with a 5 ns clock:
  // pause 200, precharge wait 3, refresh spacing ceil(12.6)=13, 8 refreshes.
  // kind: 1 precharge-all, 2 auto-refresh, 3 mode load
  localparam int N_EV = 10;
  localparam int EXP_CYC [N_EV] = '{200, 203, 216, 229, 242, 255, 268, 281, 294, 307};
  localparam int EXP_KIND[N_EV] = '{1, 2, 2, 2, 2, 2, 2, 2, 2, 3};
  localparam logic [11:0] EXP_ADDR[N_EV] = '{12'h400, 12'h000, 12'h000, 12'h000, 12'h000,
                                             12'h000, 12'h000, 12'h000, 12'h000, 12'h022};
  localparam int EXP_DONE = 309;

  int checks = 0;
  int errors = 0;
  int evCyc [16];
  int evKind[16];
  logic [11:0] evAddr[16];
  int nEv = 0;
  int doneCyc = -1;
  int ckeBad = 0;
  int doneDrops = 0;
  logic [11:0] mrsB = '0, mrsC = '0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  function automatic int kindOf(input logic ras, input logic cas, input logic we);
    if (!ras && cas && !we) return 1;
    if (!ras && !cas && we) return 2;
    if (!ras && !cas && !we) return 3;
    return 4;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (!bRas && !bCas && !bWe) mrsB = bAddr;
      if (!cRas && !cCas && !cWe) mrsC = cAddr;
    end
  end

  initial begin
    // R1: reset state while reset is held
    repeat (3) @(negedge clk);
    chk("R1", "cs_n in reset", aCs, 0);
    chk("R1", "ras/cas/we in reset", {aRas, aCas, aWe}, 3'b111);
    chk("R1", "cke and dqm in reset", {aCke, aDqm}, 3'b111);
    chk("R1", "addr and ba in reset", {aBa, aAddr}, 0);
    chk("R1", "init_done in reset", aDone, 0);
    rstN = 1'b1;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (!(aCke && (&aDqm))) ckeBad++;
      if (aCs || !aRas || !aCas || !aWe) begin
        if (nEv < 16) begin
          evCyc[nEv]  = k;
          evKind[nEv] = aCs ? 4 : kindOf(aRas, aCas, aWe);
          evAddr[nEv] = {aBa != 2'b00, aAddr[10:0]} | (aAddr & 12'h800);
        end
        nEv++;
      end
      if (aDone && doneCyc < 0) doneCyc = k;
      if (doneCyc >= 0 && !aDone) doneDrops++;
    end
    // table walk: command order, timing, encoding, address
    for (int i = 0; i < N_EV; i++) begin
      string tag;
      if (i == 0) tag = "R2 R3";
      else if (i == 1) tag = "R4";
      else if (i < N_EV - 1) tag = "R5 R6";
      else tag = "R7";
      if (i < nEv) begin
        chk(tag, $sformatf("event %0d cycle", i), evCyc[i], EXP_CYC[i]);
        chk(tag, $sformatf("event %0d kind", i), evKind[i], EXP_KIND[i]);
        chk(tag, $sformatf("event %0d address", i), evAddr[i], EXP_ADDR[i]);
      end else begin
        chk(tag, $sformatf("event %0d missing", i), 0, 1);
      end
    end
    chk("R5", "command count incl. 8 refreshes", nEv, N_EV);
    chk("R8", "mode word A: CL2 seq len4", (nEv >= N_EV) ? evAddr[N_EV-1] : 0, 12'h022);
    chk("R10", "init_done rise cycle", doneCyc, EXP_DONE);
    chk("R10", "init_done held high", doneDrops, 0);
    chk("R11", "cycles with cke or dqm low", ckeBad, 0);
    chk("R8", "mode word B: CL3 interleaved len8", mrsB & 12'h1FF, 12'h03B);
    chk("R9", "mode word B: single-write bit", mrsB[9], 1);
    chk("R9", "mode word A: burst-write bit", (nEv >= N_EV) ? evAddr[N_EV-1][9] : 1, 0);
    chk("R8", "mode word C: full page", mrsC, 12'h027);
    chk("R7", "mode word B zero fields", {bBa, mrsB[11:10], mrsB[8:7]}, 0);
    // R1: mid-run reset restarts the pause
    rstN = 1'b0;
    #1;
    chk("R1", "init_done cleared by reset", aDone, 0);
    chk("R1", "nop during reset", {aCs, aRas, aCas, aWe}, 4'b0111);
    @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "init_done low after restart", aDone, 0);
    chk("R2", "nop early in restarted pause", {aCs, aRas, aCas, aWe}, 4'b0111);
    repeat (194) @(negedge clk);
    chk("R2", "still nop at cycle 199", {aCs, aRas, aCas, aWe}, 4'b0111);
    @(negedge clk);
    chk("R3", "precharge-all at cycle 200 after restart", kindOf(aRas, aCas, aWe), 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule